// File: doc/BRIEF.md
# Dual-Channel Display Pixel Distributor

This block receives a stream of 24-bit pixels and spreads it over two 12-bit display output ports, B and C. Each output port works in half-words. An accepted pixel takes up two consecutive output slots. Slot 0 is the first pad edge and slot 1 is the second. Each port marks every slot with a valid flag and a phase bit.

Three modes are available. In single-channel mode, both halves of each pixel go out on port B, one after the other. In dual high-low mode, every pixel is split, with one half on each port. In dual odd/even mode, whole pixels alternate between the ports: even pixels go to B and odd pixels go to C. In odd/even mode the two ports start each pair of pixels in the same cycle.

A line-start pulse latches the configuration inputs and restarts pixel numbering at zero. This means each line's first pixel always lands on port B. The pixel input is a valid/ready stream. The block accepts at most one pixel per two cycles. `in_ready` falls for the one cycle after an accept and is high otherwise. A source that holds `in_valid` with stable data until it sees `in_ready` loses nothing. The output ports have no back-pressure.

Top module: `pix_dual_dist`

## Requirements
- R1: A synchronous active-high reset leaves both output valids low, both phase bits 0, `in_ready` high and the pixel count at zero. The latched mode after reset is single-channel, with swap 0 and order 0.
- R2: A pixel is accepted on a rising edge where `in_valid` and `in_ready` are both high. After an accept, `in_ready` is low in the following cycle and high again in the cycle after that. The accepted pixel's slot 0 appears in the cycle after the accept and its slot 1 in the next cycle. When no pixel is in flight, both valids are low.
- R3: Mode 2'b00 is single-channel, and mode 2'b11 is treated the same way. In single-channel mode port B carries bits [11:0] in slot 0 and bits [23:12] in slot 1 when order is 0, and the reverse when order is 1. B is valid in both slots.
- R4: In single-channel mode, port C shows data 0 with valid low for every pixel.
- R5: Mode 2'b01 is dual high-low. With swap 0, port B carries bits [11:0] and port C carries bits [23:12] in both slots.
- R6: In dual high-low mode with swap 1, port B carries bits [23:12] and port C carries bits [11:0] in both slots.
- R7: Mode 2'b10 is dual odd/even. Even-numbered pixels go to B and odd-numbered pixels go to C, with no setting that exchanges them.
- R8: In odd/even mode, when an even pixel is accepted, both ports keep their previous data with valid low for that slot pair. When an odd pixel is accepted, B shows the stored even pixel and C shows the odd pixel, starting in the same slot.
- R9: In odd/even mode, the order bit picks the half shown in slot 0 on each port: bits [11:0] when order is 0, and bits [23:12] when order is 1.
- R10: A `line_start` pulse resets the pixel count to 0. A stored even pixel that has not yet been sent is discarded. A pixel accepted in the same cycle as `line_start` is pixel 0 of the new line.
- R11: Mode, swap and order take effect only at `line_start`. A pixel accepted in the same cycle as `line_start` already uses the new values.
- R12: The phase bit is 0 in slot 0 and 1 in slot 1. In both dual modes, B and C have equal valid and phase in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Mode request: 00 single, 01 high-low, 10 odd/even, 11 single |
| cfg_swap | input | 1 | High-low half swap |
| cfg_order | input | 1 | Half order: 0 = bits [11:0] first |
| line_start | input | 1 | Line start pulse; latches configuration and restarts count |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel this cycle |
| in_pixel | input | 24 | Input pixel |
| b_data | output | 12 | Port B half-word |
| b_valid | output | 1 | Port B slot valid |
| b_phase | output | 1 | Port B slot index |
| c_data | output | 12 | Port C half-word |
| c_valid | output | 1 | Port C slot valid |
| c_phase | output | 1 | Port C slot index |

## Verification
The checker watches the timing rules on every cycle:
- the state right after reset;
- the one-cycle ready gap after each accept;
- slot 1 always following a valid slot 0, and the phase bit returning to 0;
- port C staying quiet and zero after a single-channel accept;
- B and C staying aligned after a dual-mode accept.

Only the directed scenarios can show the data routing itself:
- which half lands on which port under each swap and order setting;
- even pixels on B and odd pixels on C;
- held data during an even pair;
- a mid-line configuration change having no effect until the next line;
- a line start discarding a stored even pixel.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_HILO   = 2'b01,
    MODE_ODDEVN = 2'b10,
    MODE_SPARE  = 2'b11
  } dist_mode_e;

  typedef struct packed {
    dist_mode_e mode;
    logic       swap;
    logic       order;
  } dist_cfg_t;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_B    = 0;
  localparam int unsigned PORT_C    = 1;
endpackage

// File: rtl/pdd_cfg_latch.sv
module pdd_cfg_latch
  import pdd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic [1:0] mode_in,
  input  logic       swap_in,
  input  logic       order_in,
  output dist_cfg_t  cfg_eff,
  output dist_cfg_t  cfg_q
);
  dist_cfg_t cfg_req;

  always_comb begin
    cfg_req.mode  = dist_mode_e'(mode_in);
    cfg_req.swap  = swap_in;
    cfg_req.order = order_in;
  end

  // a pixel arriving together with line_start already uses the new settings
  assign cfg_eff = line_start ? cfg_req : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mode  <= MODE_SINGLE;
      cfg_q.swap  <= 1'b0;
      cfg_q.order <= 1'b0;
    end else if (line_start) begin
      cfg_q <= cfg_req;
    end
  end
endmodule

// File: rtl/pdd_parity.sv
module pdd_parity #(
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          accept,
  input  logic [PW-1:0] pixel,
  output logic          idx_odd,
  output logic [PW-1:0] even_pix
);
  logic cnt_q;

  // index of the pixel that would be accepted in this cycle
  assign idx_odd = line_start ? 1'b0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= ~idx_odd;
    end else if (line_start) begin
      cnt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      even_pix <= '0;
    end else if (accept && !idx_odd) begin
      even_pix <= pixel;
    end
  end
endmodule

// File: rtl/pdd_lane_map.sv
module pdd_lane_map
  import pdd_pkg::*;
#(
  parameter int unsigned HW = 12,
  localparam int unsigned PW = 2 * HW
) (
  input  dist_cfg_t                      cfg,
  input  logic                           idx_odd,
  input  logic [PW-1:0]                  pixel,
  input  logic [PW-1:0]                  even_pix,
  output logic [NUM_PORTS-1:0]           upd,
  output logic [NUM_PORTS-1:0]           vld,
  output logic [NUM_PORTS-1:0][HW-1:0]   s0,
  output logic [NUM_PORTS-1:0][HW-1:0]   s1
);
  logic [HW-1:0] cur_hi, cur_lo, evn_hi, evn_lo;

  assign cur_hi = pixel[PW-1:HW];
  assign cur_lo = pixel[HW-1:0];
  assign evn_hi = even_pix[PW-1:HW];
  assign evn_lo = even_pix[HW-1:0];

  always_comb begin
    upd = '0;
    vld = '0;
    s0  = '0;
    s1  = '0;
    unique case (cfg.mode)
      MODE_HILO: begin
        upd            = '1;
        vld            = '1;
        s0[PORT_B]     = cfg.swap ? cur_hi : cur_lo;
        s0[PORT_C]     = cfg.swap ? cur_lo : cur_hi;
        s1[PORT_B]     = s0[PORT_B];
        s1[PORT_C]     = s0[PORT_C];
      end
      MODE_ODDEVN: begin
        if (idx_odd) begin
          upd          = '1;
          vld          = '1;
          s0[PORT_B]   = cfg.order ? evn_hi : evn_lo;
          s1[PORT_B]   = cfg.order ? evn_lo : evn_hi;
          s0[PORT_C]   = cfg.order ? cur_hi : cur_lo;
          s1[PORT_C]   = cfg.order ? cur_lo : cur_hi;
        end
      end
      default: begin
        upd            = '1;
        vld[PORT_B]    = 1'b1;
        s0[PORT_B]     = cfg.order ? cur_hi : cur_lo;
        s1[PORT_B]     = cfg.order ? cur_lo : cur_hi;
      end
    endcase
  end
endmodule

// File: rtl/pdd_slot_seq.sv
module pdd_slot_seq #(
  parameter int unsigned HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          upd,
  input  logic          vld,
  input  logic [HW-1:0] s0,
  input  logic [HW-1:0] s1,
  output logic [HW-1:0] data,
  output logic          valid,
  output logic          phase
);
  logic [HW-1:0] sec_q;
  logic          sec_upd_q;
  logic          sec_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data      <= '0;
      valid     <= 1'b0;
      phase     <= 1'b0;
      sec_q     <= '0;
      sec_upd_q <= 1'b0;
      sec_vld_q <= 1'b0;
    end else if (load) begin
      if (upd) data <= s0;
      valid     <= vld;
      phase     <= 1'b0;
      sec_q     <= s1;
      sec_upd_q <= upd;
      sec_vld_q <= vld;
    end else if (step) begin
      if (sec_upd_q) data <= sec_q;
      valid     <= sec_vld_q;
      phase     <= 1'b1;
    end else begin
      valid     <= 1'b0;
      phase     <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_dual_dist.sv
module pix_dual_dist
  import pdd_pkg::*;
#(
  parameter int unsigned HW = 12,
  localparam int unsigned PW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_swap,
  input  logic          cfg_order,
  input  logic          line_start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_pixel,
  output logic [HW-1:0] b_data,
  output logic          b_valid,
  output logic          b_phase,
  output logic [HW-1:0] c_data,
  output logic          c_valid,
  output logic          c_phase
);
  dist_cfg_t                    cfg_eff, cfg_q;
  logic                         accept, slot1_due;
  logic                         idx_odd;
  logic [PW-1:0]                even_pix;
  logic [NUM_PORTS-1:0]         upd, vld;
  logic [NUM_PORTS-1:0][HW-1:0] s0, s1;
  logic [HW-1:0]                odata  [NUM_PORTS];
  logic                         ovalid [NUM_PORTS];
  logic                         ophase [NUM_PORTS];

  assign in_ready = ~slot1_due;
  assign accept   = in_valid & in_ready;

  // high while slot 0 is on the ports, so the next edge must emit slot 1
  always_ff @(posedge clk) begin
    if (rst) slot1_due <= 1'b0;
    else     slot1_due <= accept;
  end

  pdd_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .line_start(line_start),
    .mode_in(cfg_mode), .swap_in(cfg_swap), .order_in(cfg_order),
    .cfg_eff(cfg_eff), .cfg_q(cfg_q)
  );

  pdd_parity #(.PW(PW)) u_par (
    .clk(clk), .rst(rst), .line_start(line_start), .accept(accept),
    .pixel(in_pixel), .idx_odd(idx_odd), .even_pix(even_pix)
  );

  pdd_lane_map #(.HW(HW)) u_map (
    .cfg(cfg_eff), .idx_odd(idx_odd), .pixel(in_pixel), .even_pix(even_pix),
    .upd(upd), .vld(vld), .s0(s0), .s1(s1)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    pdd_slot_seq #(.HW(HW)) u_seq (
      .clk(clk), .rst(rst), .load(accept), .step(slot1_due),
      .upd(upd[g]), .vld(vld[g]), .s0(s0[g]), .s1(s1[g]),
      .data(odata[g]), .valid(ovalid[g]), .phase(ophase[g])
    );
  end

  assign b_data  = odata[PORT_B];
  assign b_valid = ovalid[PORT_B];
  assign b_phase = ophase[PORT_B];
  assign c_data  = odata[PORT_C];
  assign c_valid = ovalid[PORT_C];
  assign c_phase = ophase[PORT_C];
endmodule

// File: rtl/pdd_checker.sv
module pdd_checker
  import pdd_pkg::*;
#(
  parameter int unsigned HW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input dist_cfg_t     cfg_eff,
  input logic [HW-1:0] c_data,
  input logic          b_valid,
  input logic          b_phase,
  input logic          c_valid,
  input logic          c_phase
);
  logic acc;
  logic acc_single;
  logic acc_dual;

  assign acc        = in_valid && in_ready;
  assign acc_single = acc && (cfg_eff.mode == MODE_SINGLE || cfg_eff.mode == MODE_SPARE);
  assign acc_dual   = acc && (cfg_eff.mode == MODE_HILO || cfg_eff.mode == MODE_ODDEVN);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!b_valid && !c_valid && !b_phase && in_ready));

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> !in_ready);

  assert_slot1_follows_R12: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_phase) |=> (b_valid && b_phase));

  assert_phase_returns_R12: assert property (@(posedge clk) disable iff (rst)
    b_phase |=> !b_phase);

  assert_c_quiet_single_R4: assert property (@(posedge clk) disable iff (rst)
    acc_single |=> (!c_valid && c_data == '0));

  assert_ports_aligned_R12: assert property (@(posedge clk) disable iff (rst)
    acc_dual |=> (b_valid == c_valid && b_phase == c_phase));
endmodule

bind pix_dual_dist pdd_checker #(.HW(HW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_eff(cfg_eff), .c_data(c_data), .b_valid(b_valid), .b_phase(b_phase),
  .c_valid(c_valid), .c_phase(c_phase)
);

// File: tb/pix_dual_dist_bench.sv
`timescale 1ns/1ps
module pix_dual_dist_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_swap = 1'b0;
  logic        cfg_order = 1'b0;
  logic        line_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pixel = '0;
  logic [11:0] b_data, c_data;
  logic        b_valid, b_phase, c_valid, c_phase;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [11:0] cb [2];
  logic [11:0] cc [2];
  logic        cbv [2];
  logic        ccv [2];
  logic        cbp [2];
  logic        ccp [2];
  logic        crdy [2];

  always #5 clk = ~clk;

  pix_dual_dist u_pix_dual_dist (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_swap(cfg_swap),
    .cfg_order(cfg_order), .line_start(line_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .b_data(b_data),
    .b_valid(b_valid), .b_phase(b_phase), .c_data(c_data),
    .c_valid(c_valid), .c_phase(c_phase)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cap(input int s);
    cb[s] = b_data;  cbv[s] = b_valid; cbp[s] = b_phase;
    cc[s] = c_data;  ccv[s] = c_valid; ccp[s] = c_phase;
    crdy[s] = in_ready;
  endtask

  task automatic push(input logic [23:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    in_pixel = p;
    @(posedge clk);
    @(negedge clk);
    cap(0);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cap(1);
  endtask

  task automatic new_line(input logic [1:0] m, input logic sw, input logic ord);
    @(negedge clk);
    cfg_mode = m; cfg_swap = sw; cfg_order = ord;
    line_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "b_valid", b_valid, 0);
    chk("R1", "c_valid", c_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "b_phase", b_phase, 0);
  endtask

  task automatic t_single;
    new_line(2'b00, 1'b0, 1'b0);
    push(24'hABC123);
    chk("R3", "order0 slot0 B", {cbv[0], cbp[0], cb[0]}, {2'b10, 12'h123});
    chk("R3", "order0 slot1 B", {cbv[1], cbp[1], cb[1]}, {2'b11, 12'hABC});
    chk("R2", "ready in slot0", crdy[0], 0);
    chk("R2", "ready in slot1", crdy[1], 1);
    chk("R4", "C slot0", {ccv[0], cc[0]}, {1'b0, 12'h000});
    chk("R4", "C slot1", {ccv[1], cc[1]}, {1'b0, 12'h000});
    @(negedge clk);
    chk("R2", "idle valid", b_valid, 0);
    new_line(2'b00, 1'b0, 1'b1);
    push(24'h456DEF);
    chk("R3", "order1 slot0 B", cb[0], 12'h456);
    chk("R3", "order1 slot1 B", cb[1], 12'hDEF);
    new_line(2'b11, 1'b0, 1'b0);
    push(24'h999111);
    chk("R3", "spare mode B", {cb[0], cb[1]}, {12'h111, 12'h999});
    chk("R4", "spare mode C", ccv[0], 0);
  endtask

  task automatic t_hilo;
    new_line(2'b01, 1'b0, 1'b0);
    push(24'h9A53C7);
    chk("R5", "swap0 B", {cb[0], cb[1]}, {12'h3C7, 12'h3C7});
    chk("R5", "swap0 C", {cc[0], cc[1]}, {12'h9A5, 12'h9A5});
    chk("R12", "hilo valid/phase", {cbv[0], ccv[0], cbp[0], ccp[0], cbv[1], ccv[1], cbp[1], ccp[1]}, 8'b1100_1111);
    new_line(2'b01, 1'b1, 1'b0);
    push(24'h9A53C7);
    chk("R6", "swap1 B", {cb[0], cb[1]}, {12'h9A5, 12'h9A5});
    chk("R6", "swap1 C", {cc[0], cc[1]}, {12'h3C7, 12'h3C7});
  endtask

  task automatic t_oddeven;
    new_line(2'b10, 1'b0, 1'b0);
    push(24'h111222);
    chk("R8", "even pair valids", {cbv[0], cbv[1], ccv[0], ccv[1]}, 4'b0000);
    push(24'h333444);
    chk("R7", "B even pixel", {cb[0], cb[1]}, {12'h222, 12'h111});
    chk("R7", "C odd pixel", {cc[0], cc[1]}, {12'h444, 12'h333});
    chk("R12", "oe aligned", {cbv[0], ccv[0], cbp[0], ccp[0], cbp[1], ccp[1]}, 6'b110011);
    push(24'h555666);
    chk("R8", "held data", {cbv[0], ccv[0], cb[0], cc[0]}, {2'b00, 12'h111, 12'h333});
    push(24'h777888);
    chk("R7", "second pair", {cb[0], cb[1], cc[0], cc[1]}, {12'h666, 12'h555, 12'h888, 12'h777});
    new_line(2'b10, 1'b0, 1'b1);
    push(24'hA01B02);
    push(24'hC03D04);
    chk("R9", "order1 B", {cb[0], cb[1]}, {12'hA01, 12'hB02});
    chk("R9", "order1 C", {cc[0], cc[1]}, {12'hC03, 12'hD04});
  endtask

  task automatic t_line_reset;
    new_line(2'b10, 1'b0, 1'b0);
    push(24'hAAABBB);
    new_line(2'b10, 1'b0, 1'b0);
    push(24'h123456);
    chk("R10", "restart even", {cbv[0], ccv[0]}, 2'b00);
    push(24'h7890AB);
    chk("R10", "B from new line", cb[0], 12'h456);
    chk("R10", "C odd", cc[0], 12'h0AB);
  endtask

  task automatic t_cfg_hold;
    new_line(2'b00, 1'b0, 1'b0);
    @(negedge clk);
    cfg_mode = 2'b01;
    push(24'hFED321);
    chk("R11", "mid-line mode ignored C", ccv[0], 0);
    chk("R11", "mid-line mode ignored B", {cb[0], cb[1]}, {12'h321, 12'hFED});
    new_line(2'b01, 1'b0, 1'b0);
    push(24'hFED321);
    chk("R11", "applied at line start", {ccv[0], cc[0]}, {1'b1, 12'hFED});
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_mode = 2'b10; cfg_order = 1'b0; cfg_swap = 1'b0;
    line_start = 1'b1;
    in_valid = 1'b1;
    in_pixel = 24'h0E0F0E;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
    in_valid = 1'b0;
    chk("R10", "same-cycle pixel is even", {b_valid, c_valid}, 2'b00);
    @(posedge clk);
    push(24'h0D0C0B);
    chk("R11", "same-cycle cfg used", {cbv[0], cb[0], cc[0]}, {1'b1, 12'hF0E, 12'hC0B});
  endtask

  initial begin
    t_reset();
    t_single();
    t_hilo();
    t_oddeven();
    t_line_reset();
    t_cfg_hold();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule